// File: doc/BRIEF.md
# Guarded SIMD Accumulator Register File

This block stores the results of a vector multiply datapath. It has eight 384-bit accumulator registers. Each register is split into eight signed 48-bit lanes. A 32-bit signed product in a lane has 16 guard bits above it, so long runs of additions fit in the lane without overflow. Registers 2p and 2p+1 can also be addressed together as one 768-bit pair, with the even register in the low half.

A multiply-accumulate port takes up to sixteen signed 32-bit products. It either loads them, sign-extended, into the lanes of the target, or adds them to the lanes already there. In narrow mode, eight products go into one register. In wide mode, sixteen products go into a register pair. A plain write port and a read port give direct access to one register or to one pair.

Each lane has a sticky overflow flag. The flag is set when a signed accumulate overflows in that lane. It stays set until the lane is loaded or written.

Top module: `acc_regfile`

## Requirements
- R1: After a synchronous active-low reset, all registers read as zero, all overflow flags are 0, and `rd_valid` is 0.
- R2: When `rd_en` is high at a clock edge, `rd_valid` is high in the next cycle, and `rd_data` holds the register contents as they stood before that edge. A narrow read (`rd_wide`=0) returns register `rd_idx` in bits [383:0] and zeros in bits [767:384]. When `rd_en` is low, `rd_valid` is 0 in the next cycle.
- R3: A wide read returns {register 2p+1, register 2p} with p = `rd_idx[2:1]`. Bit `rd_idx[0]` is ignored.
- R4: A plain write with `wr_wide`=0 stores `wr_data[383:0]` into register `wr_idx`. With `wr_wide`=1 it stores `wr_data[383:0]` into register 2p and `wr_data[767:384]` into register 2p+1, with p = `wr_idx[2:1]`. Every register written has its overflow flags cleared.
- R5: A narrow load (`mac_mode`=0, `mac_load`=1) sets lane k of register `mac_idx` (bits [48k+47:48k]) to the 48-bit sign extension of product k (`mac_prod[32k+31:32k]`), for k = 0..7.
- R6: An accumulate (`mac_load`=0) adds each sign-extended product to its lane modulo 2^48. No carry passes from one lane to the next.
- R7: In wide mode (`mac_mode`=1), products 0..7 go to register 2p and products 8..15 go to register 2p+1, with p = `mac_idx[2:1]`. Bit `mac_idx[0]` is ignored.
- R8: Overflow flag bit 8r+k belongs to lane k of register r. It is set when a signed accumulate into that lane overflows. It then stays set through further accumulates and is cleared when the lane is loaded. A flag never rises on a cycle without an accumulate.
- R9: If the multiply-accumulate port and the write port target the same register in one cycle, the multiply-accumulate result is stored. A write to a different register in the same cycle still takes effect.
- R10: In cycles with neither `mac_en` nor `wr_en`, register contents and overflow flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mac_en | input | 1 | Multiply-accumulate request |
| mac_mode | input | 1 | 0: eight lanes into one register, 1: sixteen lanes into a pair |
| mac_load | input | 1 | 1: overwrite lanes, 0: add into lanes |
| mac_idx | input | 3 | Register index (narrow) or pair index in bits [2:1] (wide) |
| mac_prod | input | 512 | Sixteen signed 32-bit products, product k at bits [32k+31:32k] |
| wr_en | input | 1 | Plain write request |
| wr_wide | input | 1 | 1: write a 768-bit pair |
| wr_idx | input | 3 | Write register or pair index |
| wr_data | input | 768 | Write data |
| rd_en | input | 1 | Read request |
| rd_wide | input | 1 | 1: read a 768-bit pair |
| rd_idx | input | 3 | Read register or pair index |
| rd_data | output | 768 | Read data, one cycle after the request |
| rd_valid | output | 1 | `rd_data` holds a fresh result |
| ovf | output | 64 | Sticky per-lane overflow flags, bit 8r+k |

## Verification
A bad lane in the wrong register, a lost guard bit or a carry leaking across lanes shows up only when that register is read back. It appears in `rd_data` one cycle after the read, so the bench reads back after every kind of update. A flag that is set or cleared wrongly shows on `ovf` in the cycle right after the update that caused it. The bench compares `ovf` after every operation. Pair-aliasing faults show on a wide read or on the partner register of a narrow read. The bench reads both views of the same data.

// File: rtl/acc_pkg.sv
// Shared constants and types for the accumulator register file.
// Assumes the lane width exceeds the product width so that sign extension is meaningful.
package acc_pkg;
    localparam int ACC_NUM_REGS = 8;
    localparam int ACC_LANES    = 8;
    localparam int ACC_LANE_W   = 48;
    localparam int ACC_IN_W     = 32;

    // Accumulation mode selected on the multiply-accumulate port.
    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_PAIR   = 1'b1
    } acc_mode_e;
endpackage

// File: rtl/acc_lane.sv
// One accumulator lane: computes the next value of a lane from its current value and one product.
// Purely combinational. Assumes LANE_W > IN_W; additions wrap modulo 2^LANE_W.
module acc_lane #(
    parameter int LANE_W = 48,
    parameter int IN_W   = 32
) (
    input  logic [LANE_W-1:0] cur,
    input  logic [IN_W-1:0]   prod,
    input  logic              load,
    output logic [LANE_W-1:0] nxt,
    output logic              ovf
);
    localparam int EXT_W = LANE_W - IN_W;

    logic [LANE_W-1:0] ext;
    logic [LANE_W-1:0] sum;

    // Sign extension of the product and the wrapped lane sum.
    always_comb begin
        ext = {{EXT_W{prod[IN_W-1]}}, prod};
        sum = cur + ext;
    end

    // Select load or accumulate; flag signed overflow of the addition.
    always_comb begin
        if (load) begin
            nxt = ext;
            ovf = 1'b0;
        end else begin
            nxt = sum;
            ovf = (cur[LANE_W-1] == ext[LANE_W-1]) && (sum[LANE_W-1] != cur[LANE_W-1]);
        end
    end
endmodule

// File: rtl/acc_bank.sv
// One accumulator register of LANES lanes, with its sticky overflow flags.
// A multiply-accumulate hit takes priority over a plain write hit in the same cycle.
// Assumes the caller has already selected the product and write slices for this register.
module acc_bank #(
    parameter int LANES  = 8,
    parameter int LANE_W = 48,
    parameter int IN_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mac_hit,
    input  logic                    mac_load,
    input  logic [LANES*IN_W-1:0]   prod,
    input  logic                    wr_hit,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] q,
    output logic [LANES-1:0]        ovf
);
    logic [LANES*LANE_W-1:0] nxt;
    logic [LANES-1:0]        lane_ovf;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        acc_lane #(
            .LANE_W(LANE_W),
            .IN_W  (IN_W)
        ) u_lane (
            .cur (q[k*LANE_W +: LANE_W]),
            .prod(prod[k*IN_W +: IN_W]),
            .load(mac_load),
            .nxt (nxt[k*LANE_W +: LANE_W]),
            .ovf (lane_ovf[k])
        );
    end

    // Register update: reset, multiply-accumulate, then plain write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= '0;
            ovf <= '0;
        end else if (mac_hit) begin
            q   <= nxt;
            ovf <= mac_load ? '0 : (ovf | lane_ovf);
        end else if (wr_hit) begin
            q   <= wr_data;
            ovf <= '0;
        end
    end
endmodule

// File: rtl/acc_read_port.sv
// Registered read port: returns one register (zero-extended) or an even/odd pair.
// Assumes NUM_REGS is even; the low index bit is ignored for pair reads.
module acc_read_port #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 384,
    parameter int IDX_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               rd_wide,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [REG_W-1:0]   regs [NUM_REGS],
    output logic [2*REG_W-1:0] rd_data,
    output logic               rd_valid
);
    logic [IDX_W-1:0]   lo_idx;
    logic [IDX_W-1:0]   hi_idx;
    logic [2*REG_W-1:0] sel;

    // Pick the addressed register or pair.
    always_comb begin
        lo_idx = {rd_idx[IDX_W-1:1], 1'b0};
        hi_idx = {rd_idx[IDX_W-1:1], 1'b1};
        if (rd_wide) begin
            sel = {regs[hi_idx], regs[lo_idx]};
        end else begin
            sel = {{REG_W{1'b0}}, regs[rd_idx]};
        end
    end

    // Capture the selection one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= sel;
            end
        end
    end
endmodule

// File: rtl/acc_regfile.sv
// Guarded SIMD accumulator register file: NUM_REGS registers of LANES signed lanes,
// addressable singly or as even/odd pairs, with load/accumulate of per-lane products.
// Assumes NUM_REGS is even and a power of two.
module acc_regfile
    import acc_pkg::*;
#(
    parameter int NUM_REGS = ACC_NUM_REGS,
    parameter int LANES    = ACC_LANES,
    parameter int LANE_W   = ACC_LANE_W,
    parameter int IN_W     = ACC_IN_W,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int REG_W   = LANES * LANE_W,
    localparam int PAIR_W  = 2 * REG_W,
    localparam int RPROD_W = LANES * IN_W,
    localparam int PROD_W  = 2 * RPROD_W,
    localparam int OVF_W   = NUM_REGS * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mac_en,
    input  logic              mac_mode,
    input  logic              mac_load,
    input  logic [IDX_W-1:0]  mac_idx,
    input  logic [PROD_W-1:0] mac_prod,
    input  logic              wr_en,
    input  logic              wr_wide,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PAIR_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_wide,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PAIR_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [OVF_W-1:0]  ovf
);
    acc_mode_e        mode;
    logic [REG_W-1:0] regs [NUM_REGS];

    // Decode the mode input into the shared type.
    always_comb begin
        mode = acc_mode_e'(mac_mode);
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_bank
        localparam logic [IDX_W-1:0] REG_IDX  = IDX_W'(i);
        localparam logic [IDX_W-2:0] PAIR_IDX = (IDX_W-1)'(i / 2);
        localparam bit               IS_HI    = (i % 2) == 1;

        logic               mac_hit;
        logic               wr_hit;
        logic [RPROD_W-1:0] prod_sl;
        logic [REG_W-1:0]   wr_sl;

        // Address decode and data slice selection for this register.
        always_comb begin
            if (mode == MODE_PAIR) begin
                mac_hit = mac_en && (mac_idx[IDX_W-1:1] == PAIR_IDX);
            end else begin
                mac_hit = mac_en && (mac_idx == REG_IDX);
            end
            if (wr_wide) begin
                wr_hit = wr_en && (wr_idx[IDX_W-1:1] == PAIR_IDX);
            end else begin
                wr_hit = wr_en && (wr_idx == REG_IDX);
            end
            if (IS_HI && mode == MODE_PAIR) begin
                prod_sl = mac_prod[PROD_W-1:RPROD_W];
            end else begin
                prod_sl = mac_prod[RPROD_W-1:0];
            end
            if (IS_HI && wr_wide) begin
                wr_sl = wr_data[PAIR_W-1:REG_W];
            end else begin
                wr_sl = wr_data[REG_W-1:0];
            end
        end

        acc_bank #(
            .LANES (LANES),
            .LANE_W(LANE_W),
            .IN_W  (IN_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .mac_hit (mac_hit),
            .mac_load(mac_load),
            .prod    (prod_sl),
            .wr_hit  (wr_hit),
            .wr_data (wr_sl),
            .q       (regs[i]),
            .ovf     (ovf[i*LANES +: LANES])
        );
    end

    acc_read_port #(
        .NUM_REGS(NUM_REGS),
        .REG_W   (REG_W),
        .IDX_W   (IDX_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_wide (rd_wide),
        .rd_idx  (rd_idx),
        .regs    (regs),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );
endmodule

// File: rtl/acc_regfile_chk.sv
// Protocol and flag checker for the accumulator register file, bound to every instance.
// Observes only the top-level ports.
module acc_regfile_chk #(
    parameter int IDX_W  = 3,
    parameter int LANES  = 8,
    parameter int REG_W  = 384,
    parameter int OVF_W  = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mac_en,
    input logic               mac_mode,
    input logic               mac_load,
    input logic [IDX_W-1:0]   mac_idx,
    input logic               wr_en,
    input logic               wr_wide,
    input logic [IDX_W-1:0]   wr_idx,
    input logic               rd_en,
    input logic               rd_wide,
    input logic [2*REG_W-1:0] rd_data,
    input logic               rd_valid,
    input logic [OVF_W-1:0]   ovf
);
    // R2
    rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R2
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R2
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_wide) |=> (rd_data[2*REG_W-1:REG_W] == '0));

    // R8
    load_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && mac_load && !mac_mode && mac_idx == '0) |=> (ovf[LANES-1:0] == '0));

    // R4
    write_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mac_en && !wr_wide && wr_idx == '0) |=> (ovf[LANES-1:0] == '0));

    // R8
    flag_rise_only_on_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mac_en && !mac_load) |=> ((ovf & ~$past(ovf)) == '0));

    // R10
    idle_flags_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mac_en && !wr_en) |=> $stable(ovf));
endmodule

bind acc_regfile acc_regfile_chk #(
    .IDX_W(IDX_W),
    .LANES(LANES),
    .REG_W(REG_W),
    .OVF_W(OVF_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mac_en  (mac_en),
    .mac_mode(mac_mode),
    .mac_load(mac_load),
    .mac_idx (mac_idx),
    .wr_en   (wr_en),
    .wr_wide (wr_wide),
    .wr_idx  (wr_idx),
    .rd_en   (rd_en),
    .rd_wide (rd_wide),
    .rd_data (rd_data),
    .rd_valid(rd_valid),
    .ovf     (ovf)
);

// File: tb/acc_regfile_tb.sv
// Scoreboard bench: driver tasks update a reference model and queue expected reads;
// a monitor pops and compares on each valid read result.
module acc_regfile_tb;
    localparam int NR = 8;
    localparam int L  = 8;
    localparam int LW = 48;
    localparam int IW = 32;
    localparam int RW = L * LW;
    localparam int PW = 2 * RW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mac_en = 1'b0, mac_mode = 1'b0, mac_load = 1'b0;
    logic [2:0]    mac_idx = '0;
    logic [2*L*IW-1:0] mac_prod = '0;
    logic          wr_en = 1'b0, wr_wide = 1'b0;
    logic [2:0]    wr_idx = '0;
    logic [PW-1:0] wr_data = '0;
    logic          rd_en = 1'b0, rd_wide = 1'b0;
    logic [2:0]    rd_idx = '0;
    logic [PW-1:0] rd_data;
    logic          rd_valid;
    logic [NR*L-1:0] ovf;

    int checks = 0;
    int errors = 0;

    logic [RW-1:0]   mreg [NR];
    logic [NR*L-1:0] movf;
    logic [IW-1:0]   pv [2*L];
    logic [PW-1:0]   exp_q [$];
    string           req_q [$];

    always #10 clk = ~clk;

    acc_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .mac_en(mac_en), .mac_mode(mac_mode), .mac_load(mac_load),
        .mac_idx(mac_idx), .mac_prod(mac_prod),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_wide(rd_wide), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_valid(rd_valid), .ovf(ovf)
    );

    function automatic logic [LW-1:0] sx(input logic [IW-1:0] p);
        return {{(LW-IW){p[IW-1]}}, p};
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_mac(input int r, input int base, input bit load);
        for (int k = 0; k < L; k++) begin
            logic [LW-1:0] a, s, n;
            a = mreg[r][k*LW +: LW];
            s = sx(pv[base+k]);
            if (load) begin
                n = s;
                movf[r*L+k] = 1'b0;
            end else begin
                n = a + s;
                if (a[LW-1] == s[LW-1] && n[LW-1] != a[LW-1]) movf[r*L+k] = 1'b1;
            end
            mreg[r][k*LW +: LW] = n;
        end
    endtask

    // Drive one update cycle and mirror it in the model; then compare flags.
    task automatic do_op(input string req, input bit me, input bit mm, input bit ml,
                         input logic [2:0] mi, input bit we, input bit ww,
                         input logic [2:0] wi, input logic [PW-1:0] wd);
        int e;
        mac_en = me; mac_mode = mm; mac_load = ml; mac_idx = mi;
        wr_en = we; wr_wide = ww; wr_idx = wi; wr_data = wd;
        for (int k = 0; k < 2*L; k++) mac_prod[k*IW +: IW] = pv[k];
        if (we) begin
            if (ww) begin
                e = int'(wi >> 1) * 2;
                mreg[e] = wd[RW-1:0];
                mreg[e+1] = wd[PW-1:RW];
                movf[e*L +: L] = '0;
                movf[(e+1)*L +: L] = '0;
            end else begin
                mreg[wi] = wd[RW-1:0];
                movf[int'(wi)*L +: L] = '0;
            end
        end
        if (me) begin
            if (mm) begin
                e = int'(mi >> 1) * 2;
                model_mac(e, 0, ml);
                model_mac(e + 1, L, ml);
            end else begin
                model_mac(int'(mi), 0, ml);
            end
        end
        @(posedge clk);
        #1;
        mac_en = 1'b0; wr_en = 1'b0;
        check({req, " flags"}, PW'(ovf), PW'(movf));
    endtask

    // Request a read and queue the expected result from the model.
    task automatic do_read(input string req, input bit w, input logic [2:0] idx);
        int e;
        if (w) begin
            e = int'(idx >> 1) * 2;
            exp_q.push_back({mreg[e+1], mreg[e]});
        end else begin
            exp_q.push_back({{RW{1'b0}}, mreg[idx]});
        end
        req_q.push_back(req);
        rd_en = 1'b1; rd_wide = w; rd_idx = idx;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    // Monitor: compare each valid read result against the queue head.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 actual=unexpected rd_valid expected=no result");
            end else begin
                check(req_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [PW-1:0] d;
        for (int r = 0; r < NR; r++) mreg[r] = '0;
        movf = '0;
        for (int k = 0; k < 2*L; k++) pv[k] = '0;

        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        check("R1 flags", PW'(ovf), '0);
        check("R1 rd_valid", PW'(rd_valid), '0);
        for (int r = 0; r < NR; r++) do_read("R1 reg zero", 1'b0, 3'(r));
        idle(2);

        // R4: narrow write, then narrow and wide reads (R2, R3)
        d = '0;
        d[RW-1:0] = {12{32'h1234_5678}} ^ {6{64'h0F0F_0000_F0F0_1111}};
        do_op("R4 narrow write", 0, 0, 0, 0, 1, 0, 3'd3, d);
        do_read("R2 narrow read", 1'b0, 3'd3);
        do_read("R3 wide read odd idx", 1'b1, 3'd3);
        do_read("R3 wide read even idx", 1'b1, 3'd2);

        // R4: wide write to pair 2 via odd index
        d = {{12{32'hCAFE_0001}}, {12{32'hBEEF_0002}}};
        do_op("R4 wide write", 0, 0, 0, 0, 1, 1, 3'd5, d);
        do_read("R4 wide readback", 1'b1, 3'd4);
        do_read("R4 low half narrow", 1'b0, 3'd4);
        do_read("R4 high half narrow", 1'b0, 3'd5);

        // R5: narrow load with mixed signs
        for (int k = 0; k < L; k++) pv[k] = 32'(k * 1000 - 3000);
        do_op("R5 load", 1, 0, 1, 3'd5, 0, 0, 0, '0);
        do_read("R5 load readback", 1'b0, 3'd5);

        // R6: accumulate twice
        for (int k = 0; k < L; k++) pv[k] = 32'hFFFF_FFF0 + 32'(k);
        do_op("R6 accumulate", 1, 0, 0, 3'd5, 0, 0, 0, '0);
        for (int k = 0; k < L; k++) pv[k] = 32'h7FFF_FFFF - 32'(k);
        do_op("R6 accumulate again", 1, 0, 0, 3'd5, 0, 0, 0, '0);
        do_read("R6 accumulate readback", 1'b0, 3'd5);

        // R6/R8: overflow, wrap and no inter-lane carry on register 0
        d = '0;
        d[0*LW +: LW] = 48'h7FFF_FFFF_FFFF;
        d[1*LW +: LW] = 48'hFFFF_FFFF_FFFF;
        d[2*LW +: LW] = 48'h8000_0000_0000;
        do_op("R4 seed reg0", 0, 0, 0, 0, 1, 0, 3'd0, d);
        for (int k = 0; k < 2*L; k++) pv[k] = '0;
        pv[0] = 32'd1; pv[1] = 32'd1; pv[2] = 32'hFFFF_FFFF;
        do_op("R8 overflow set", 1, 0, 0, 3'd0, 0, 0, 0, '0);
        do_read("R6 wrap no carry", 1'b0, 3'd0);
        for (int k = 0; k < 2*L; k++) pv[k] = '0;
        do_op("R8 flag sticky", 1, 0, 0, 3'd0, 0, 0, 0, '0);
        idle(3);
        // R10: idle cycles leave flags and contents alone
        check("R10 flags idle", PW'(ovf), PW'(movf));
        do_read("R10 contents idle", 1'b0, 3'd0);
        do_op("R8 load clears", 1, 0, 1, 3'd0, 0, 0, 0, '0);

        // R7: sixteen-lane load via odd index, then accumulate
        for (int k = 0; k < 2*L; k++) pv[k] = 32'(k * 7 - 50);
        do_op("R7 pair load", 1, 1, 1, 3'd7, 0, 0, 0, '0);
        do_read("R7 pair load readback", 1'b1, 3'd6);
        for (int k = 0; k < 2*L; k++) pv[k] = 32'(40000 - k * 9000);
        do_op("R7 pair accumulate", 1, 1, 0, 3'd6, 0, 0, 0, '0);
        do_read("R7 pair acc readback", 1'b1, 3'd7);

        // R9: collision on register 1, then parallel write to register 4
        for (int k = 0; k < L; k++) pv[k] = 32'(k + 100);
        d = {24{32'h5555_AAAA}};
        do_op("R9 same reg", 1, 0, 1, 3'd1, 1, 0, 3'd1, d);
        do_read("R9 mac wins", 1'b0, 3'd1);
        d = {24{32'h0BAD_F00D}};
        do_op("R9 other reg", 1, 0, 0, 3'd1, 1, 0, 3'd4, d);
        do_read("R9 write elsewhere", 1'b0, 3'd4);
        do_read("R9 mac elsewhere", 1'b0, 3'd1);

        idle(3);
        check("R2 all reads returned", PW'(exp_q.size()), '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule